// File: doc/BRIEF.md
# Shared-Memory Doorbell Register Block

This block is the small register window of a device that lets several software domains exchange data through a common memory region. It holds a 32-bit interrupt enable mask, a 32-bit interrupt status word, a read-only identity word and a write-only doorbell. A level interrupt is raised while any status bit is also enabled in the mask. Reading the status word returns its contents and empties it in the same access, so a handler acknowledges by reading. A separate event input, driven by the receiving side of the channel, loads the status word.

A doorbell write packs a destination peer and a vector number into one word. The block checks the pair against a table that holds, for each peer, how many vectors that peer has registered. Only an accepted pair produces a one-cycle notify strobe carrying the peer and the vector, which the surrounding logic turns into a message toward that peer. The table is filled through its own write port. The highest peer index with a nonzero count is taken as the largest valid destination.

Top module: `shm_doorbell_regs`

## Requirements
- R1: While `rst_ni` is low and after it is released, the status and mask words are zero, `irq_o` is 0, `notify_o` is 0, `rdata_o` is 0 and every peer count is 0.
- R2: `irq_o` is 1 exactly when the bitwise AND of status and mask is nonzero, and it shows the state of those registers from the cycle after each change.
- R3: A word write replaces the whole mask at offset 0x00 or the whole status word at offset 0x04. Writes ignore address bits 1:0, so offset 0x07 selects the status word and 0x0F selects the doorbell.
- R4: A word read at offset 0x04 returns the status word, and the status word is zero afterwards. `irq_o` falls accordingly.
- R5: Only word accesses (`size_i` = 2) have effect. `size_i` = 0 (byte), 1 (half) and 3 give writes that change nothing and send no doorbell, and reads that return 0 and do not clear the status word.
- R6: Reads decode the full byte address. 0x00 returns the mask. 0x08 returns `{16'h0, local_id_i}` when `mapped_i` is 1 and 0xFFFFFFFF otherwise. Any other address except 0x04, including the doorbell at 0x0C and unaligned addresses, reads as 0.
- R7: A cycle with `evt_valid_i` high replaces the whole status word with `evt_data_i` zero-extended to 32 bits.
- R8: When an event arrives in the same cycle as a status read or a status write, the event value is what the status word holds afterwards. The read still returns the old value.
- R9: A doorbell word carries the destination peer in bits 31:16 and the vector in bits 7:0. Bits 15:8 are ignored.
- R10: A doorbell is dropped, with no strobe, when its destination is above the highest peer index holding a nonzero count (0 when none does), or when its vector is not below that destination's count.
- R11: An accepted doorbell raises `notify_o` for exactly the one cycle after the write, with `notify_peer_o` and `notify_vec_o` holding the decoded destination and vector.
- R12: A table write with `tbl_we_i` sets the count of entry `tbl_idx_i` to `tbl_cnt_i`, and it is in force for doorbells from the next cycle. Setting a count to zero removes the peer, and the highest valid peer index follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W (8) | Byte offset within the 0x100 window |
| size_i | input | 2 | Access size: 0 byte, 1 half, 2 word, 3 reserved |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| irq_o | output | 1 | Level interrupt |
| evt_valid_i | input | 1 | Incoming event strobe |
| evt_data_i | input | 8 | Event value loaded into status |
| mapped_i | input | 1 | Shared region is mapped |
| local_id_i | input | 16 | Local peer identity |
| tbl_we_i | input | 1 | Peer table write |
| tbl_idx_i | input | IDX_W (4) | Peer table entry |
| tbl_cnt_i | input | CNT_W (8) | Vector count for the entry |
| notify_o | output | 1 | Doorbell accepted strobe |
| notify_peer_o | output | 16 | Destination of the accepted doorbell |
| notify_vec_o | output | 8 | Vector of the accepted doorbell |

## Verification
Each result is registered once: read data and the notify strobe with its fields appear one clock after the accepting edge, and `irq_o` reflects the mask and status registers written at that same edge. The bench drives inputs on the falling edge, lets one rising edge capture them, and samples on the next falling edge, where every one-cycle result is already settled. The strobe is sampled a second time one cycle later to show that it lasts a single cycle. Simultaneous event and status access are driven within one falling-edge window so that both land on the same rising edge.

// File: rtl/shm_db_pkg.sv
package shm_db_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  localparam int unsigned DATA_W   = 32;
  localparam int unsigned PEER_W   = 16;
  localparam int unsigned VEC_W    = 8;
  localparam int unsigned EVT_W    = 8;
  localparam int unsigned ID_W     = 16;

  localparam logic [7:0] OFF_MASK = 8'h00;
  localparam logic [7:0] OFF_STAT = 8'h04;
  localparam logic [7:0] OFF_POS  = 8'h08;
  localparam logic [7:0] OFF_BELL = 8'h0C;
endpackage

// File: rtl/shm_db_irq_regs.sv
module shm_db_irq_regs #(
  parameter int unsigned DW   = 32,
  parameter int unsigned EW   = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mask_we_i,
  input  logic          stat_we_i,
  input  logic          stat_rd_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          evt_valid_i,
  input  logic [EW-1:0] evt_data_i,
  output logic [DW-1:0] mask_o,
  output logic [DW-1:0] stat_o,
  output logic          irq_o
);
  logic [DW-1:0] mask_q, stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      stat_q <= '0;
    end else begin
      if (mask_we_i) mask_q <= wdata_i;
      // event has priority so an arriving event is never lost
      if (evt_valid_i)    stat_q <= DW'(evt_data_i);
      else if (stat_we_i) stat_q <= wdata_i;
      else if (stat_rd_i) stat_q <= '0;
    end
  end

  assign mask_o = mask_q;
  assign stat_o = stat_q;
  assign irq_o  = |(stat_q & mask_q);

  assert_evt_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_i |=> stat_q == DW'($past(evt_data_i)));

  assert_rdclr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd_i && !evt_valid_i && !stat_we_i) |=> (stat_q == '0 && !irq_o));

  assert_mask_off_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_we_i && wdata_i == '0) |=> !irq_o);
endmodule

// File: rtl/shm_db_peer_table.sv
module shm_db_peer_table #(
  parameter int unsigned NUM_PEERS = 16,
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned PEER_W    = 16,
  parameter int unsigned IDX_W     = (NUM_PEERS > 1) ? $clog2(NUM_PEERS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tbl_we_i,
  input  logic [IDX_W-1:0]  tbl_idx_i,
  input  logic [CNT_W-1:0]  tbl_cnt_i,
  input  logic [PEER_W-1:0] lkp_peer_i,
  output logic [CNT_W-1:0]  lkp_cnt_o,
  output logic [PEER_W-1:0] max_peer_o
);
  logic [CNT_W-1:0] cnt_q [NUM_PEERS];
  logic [NUM_PEERS-1:0] nz;

  for (genvar g = 0; g < NUM_PEERS; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     cnt_q[g] <= '0;
      else if (tbl_we_i && tbl_idx_i == IDX_W'(g))     cnt_q[g] <= tbl_cnt_i;
    end
    assign nz[g] = |cnt_q[g];
  end

  always_comb begin
    max_peer_o = '0;
    for (int i = 0; i < NUM_PEERS; i++) begin
      if (nz[i]) max_peer_o = PEER_W'(i);
    end
  end

  always_comb begin
    lkp_cnt_o = '0;
    if (lkp_peer_i < PEER_W'(NUM_PEERS)) lkp_cnt_o = cnt_q[lkp_peer_i[IDX_W-1:0]];
  end

  assert_max_nonzero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (max_peer_o == '0) || nz[max_peer_o[IDX_W-1:0]]);

  assert_tbl_write_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tbl_we_i && tbl_cnt_i != '0) |=> max_peer_o >= PEER_W'($past(tbl_idx_i)));
endmodule

// File: rtl/shm_db_bell.sv
module shm_db_bell #(
  parameter int unsigned PEER_W = 16,
  parameter int unsigned VEC_W  = 8,
  parameter int unsigned CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bell_we_i,
  input  logic [PEER_W-1:0] dest_i,
  input  logic [VEC_W-1:0]  vec_i,
  input  logic [PEER_W-1:0] max_peer_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              notify_o,
  output logic [PEER_W-1:0] notify_peer_o,
  output logic [VEC_W-1:0]  notify_vec_o
);
  localparam int unsigned CMP_W = (VEC_W > CNT_W) ? VEC_W : CNT_W;

  logic accept;
  assign accept = bell_we_i && (dest_i <= max_peer_i) && (CMP_W'(vec_i) < CMP_W'(cnt_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      notify_o      <= 1'b0;
      notify_peer_o <= '0;
      notify_vec_o  <= '0;
    end else begin
      notify_o <= accept;
      if (accept) begin
        notify_peer_o <= dest_i;
        notify_vec_o  <= vec_i;
      end
    end
  end

  assert_notify_src_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    notify_o |-> $past(bell_we_i));

  assert_drop_dest_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bell_we_i && dest_i > max_peer_i) |=> !notify_o);

  assert_drop_vec_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    notify_o |-> CMP_W'(notify_vec_o) < CMP_W'($past(cnt_i)));
endmodule

// File: rtl/shm_doorbell_regs.sv
module shm_doorbell_regs
  import shm_db_pkg::*;
#(
  parameter int unsigned NUM_PEERS = 16,
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned IDX_W     = (NUM_PEERS > 1) ? $clog2(NUM_PEERS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o,
  input  logic              evt_valid_i,
  input  logic [7:0]        evt_data_i,
  input  logic              mapped_i,
  input  logic [15:0]       local_id_i,
  input  logic              tbl_we_i,
  input  logic [IDX_W-1:0]  tbl_idx_i,
  input  logic [CNT_W-1:0]  tbl_cnt_i,
  output logic              notify_o,
  output logic [15:0]       notify_peer_o,
  output logic [7:0]        notify_vec_o
);
  logic              is_word, wr_en, rd_en;
  logic [ADDR_W-1:0] waddr;
  logic              mask_we, stat_we, stat_rd, bell_we;
  logic [DATA_W-1:0] mask_w, stat_w, rd_mux;
  logic [PEER_W-1:0] dest, max_peer;
  logic [VEC_W-1:0]  vec;
  logic [CNT_W-1:0]  dest_cnt;

  assign is_word = (size_i == SZ_WORD);
  assign wr_en   = req_i && we_i && is_word;
  assign rd_en   = req_i && !we_i;
  // writes drop the byte lane bits, reads decode the full offset
  assign waddr   = {addr_i[ADDR_W-1:2], 2'b00};

  assign mask_we = wr_en && (waddr == ADDR_W'(OFF_MASK));
  assign stat_we = wr_en && (waddr == ADDR_W'(OFF_STAT));
  assign bell_we = wr_en && (waddr == ADDR_W'(OFF_BELL));
  assign stat_rd = rd_en && is_word && (addr_i == ADDR_W'(OFF_STAT));

  assign dest = wdata_i[DATA_W-1 -: PEER_W];
  assign vec  = wdata_i[VEC_W-1:0];

  shm_db_irq_regs #(.DW(DATA_W), .EW(EVT_W)) u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mask_we_i  (mask_we),
    .stat_we_i  (stat_we),
    .stat_rd_i  (stat_rd),
    .wdata_i    (wdata_i),
    .evt_valid_i(evt_valid_i),
    .evt_data_i (evt_data_i),
    .mask_o     (mask_w),
    .stat_o     (stat_w),
    .irq_o      (irq_o)
  );

  shm_db_peer_table #(
    .NUM_PEERS(NUM_PEERS), .CNT_W(CNT_W), .PEER_W(PEER_W), .IDX_W(IDX_W)
  ) u_tbl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tbl_we_i  (tbl_we_i),
    .tbl_idx_i (tbl_idx_i),
    .tbl_cnt_i (tbl_cnt_i),
    .lkp_peer_i(dest),
    .lkp_cnt_o (dest_cnt),
    .max_peer_o(max_peer)
  );

  shm_db_bell #(.PEER_W(PEER_W), .VEC_W(VEC_W), .CNT_W(CNT_W)) u_bell (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bell_we_i    (bell_we),
    .dest_i       (dest),
    .vec_i        (vec),
    .max_peer_i   (max_peer),
    .cnt_i        (dest_cnt),
    .notify_o     (notify_o),
    .notify_peer_o(notify_peer_o),
    .notify_vec_o (notify_vec_o)
  );

  always_comb begin
    rd_mux = '0;
    if (is_word) begin
      if      (addr_i == ADDR_W'(OFF_MASK)) rd_mux = mask_w;
      else if (addr_i == ADDR_W'(OFF_STAT)) rd_mux = stat_w;
      else if (addr_i == ADDR_W'(OFF_POS))  rd_mux = mapped_i ? DATA_W'(local_id_i) : '1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rdata_o <= '0;
    else if (rd_en) rdata_o <= rd_mux;
  end

  assert_nonword_rd_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en && !is_word) |=> rdata_o == '0);

  assert_nonword_wr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && !is_word && !evt_valid_i) |=> ($stable(stat_w) && $stable(mask_w) && !notify_o));

  assert_pos_unmapped_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en && is_word && addr_i == ADDR_W'(OFF_POS) && !mapped_i) |=> rdata_o == '1);
endmodule

// File: tb/sim_shm_doorbell_regs.sv
`timescale 1ns/1ps
module sim_shm_doorbell_regs;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [1:0]  size = '0;
  logic [31:0] wdata = '0, rdata;
  logic        irq;
  logic        evt_valid = 1'b0;
  logic [7:0]  evt_data = '0;
  logic        mapped = 1'b1;
  logic [15:0] local_id = 16'h0005;
  logic        tbl_we = 1'b0;
  logic [3:0]  tbl_idx = '0;
  logic [7:0]  tbl_cnt = '0;
  logic        notify;
  logic [15:0] notify_peer;
  logic [7:0]  notify_vec;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  shm_doorbell_regs u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .size_i(size), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq),
    .evt_valid_i(evt_valid), .evt_data_i(evt_data), .mapped_i(mapped),
    .local_id_i(local_id), .tbl_we_i(tbl_we), .tbl_idx_i(tbl_idx),
    .tbl_cnt_i(tbl_cnt), .notify_o(notify), .notify_peer_o(notify_peer),
    .notify_vec_o(notify_vec)
  );

  // {is_write, addr, size, data (wdata or expected rdata), expected irq}
  localparam int NV = 22;
  localparam logic [43:0] VEC [NV] = '{
    {1'b0, 8'h00, 2'd2, 32'h0000_0000, 1'b0}, // R6 mask reads 0
    {1'b1, 8'h00, 2'd2, 32'h0000_00F0, 1'b0}, // R3 mask write
    {1'b1, 8'h04, 2'd2, 32'h0000_0010, 1'b1}, // R2 R3 status write
    {1'b0, 8'h00, 2'd2, 32'h0000_00F0, 1'b1}, // R6 mask readback
    {1'b0, 8'h04, 2'd2, 32'h0000_0010, 1'b0}, // R4 read clears
    {1'b0, 8'h04, 2'd2, 32'h0000_0000, 1'b0}, // R4 now empty
    {1'b1, 8'h04, 2'd0, 32'h0000_0010, 1'b0}, // R5 byte write ignored
    {1'b1, 8'h04, 2'd1, 32'h0000_0030, 1'b0}, // R5 half write ignored
    {1'b0, 8'h04, 2'd2, 32'h0000_0000, 1'b0}, // R5 status untouched
    {1'b1, 8'h04, 2'd2, 32'h0000_000F, 1'b0}, // R2 unmasked bits only
    {1'b0, 8'h04, 2'd2, 32'h0000_000F, 1'b0}, // R4
    {1'b1, 8'h07, 2'd2, 32'h0000_0020, 1'b1}, // R3 low addr bits dropped
    {1'b0, 8'h04, 2'd1, 32'h0000_0000, 1'b1}, // R5 half read 0, no clear
    {1'b0, 8'h04, 2'd2, 32'h0000_0020, 1'b0}, // R4
    {1'b0, 8'h08, 2'd2, 32'h0000_0005, 1'b0}, // R6 position mapped
    {1'b0, 8'h20, 2'd2, 32'h0000_0000, 1'b0}, // R6 undefined offset
    {1'b0, 8'h0C, 2'd2, 32'h0000_0000, 1'b0}, // R6 doorbell reads 0
    {1'b0, 8'h01, 2'd2, 32'h0000_0000, 1'b0}, // R6 unaligned read
    {1'b1, 8'h00, 2'd3, 32'h0000_00FF, 1'b0}, // R5 size 3 ignored
    {1'b0, 8'h00, 2'd2, 32'h0000_00F0, 1'b0}, // R5 mask kept
    {1'b1, 8'h04, 2'd2, 32'hFFFF_FFF0, 1'b1}, // R3 full word
    {1'b0, 8'h04, 2'd2, 32'hFFFF_FFF0, 1'b0}  // R4
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic w, input logic [7:0] a, input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; size = s; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic evt(input logic [7:0] d);
    @(negedge clk);
    evt_valid = 1'b1; evt_data = d;
    @(negedge clk);
    evt_valid = 1'b0;
  endtask

  task automatic tbl(input logic [3:0] i, input logic [7:0] c);
    @(negedge clk);
    tbl_we = 1'b1; tbl_idx = i; tbl_cnt = c;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic bell(input string tag, input logic [1:0] s, input logic [7:0] a,
                      input logic [31:0] d, input logic exp_n,
                      input logic [15:0] exp_p, input logic [7:0] exp_v);
    bus(1'b1, a, s, d);
    check({tag, " notify"}, 32'(notify), 32'(exp_n));
    if (exp_n) begin
      check({tag, " peer"}, 32'(notify_peer), 32'(exp_p));
      check({tag, " vec"}, 32'(notify_vec), 32'(exp_v));
    end
    @(negedge clk);
    check({tag, " strobe ends"}, 32'(notify), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rdata in reset", rdata, 32'h0);
    check("R1 irq in reset", 32'(irq), 32'h0);
    check("R1 notify in reset", 32'(notify), 32'h0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [43:0] v;
      v = VEC[i];
      bus(v[43], v[42:35], v[34:33], v[32:1]);
      if (!v[43]) check($sformatf("R4/R5/R6 vec %0d rdata", i), rdata, v[32:1]);
      check($sformatf("R2 vec %0d irq", i), 32'(irq), 32'(v[0]));
    end

    // R6 unmapped position
    mapped = 1'b0;
    bus(1'b0, 8'h08, 2'd2, 32'h0);
    check("R6 unmapped position", rdata, 32'hFFFF_FFFF);
    mapped = 1'b1;

    // R7 event replaces whole word
    bus(1'b1, 8'h04, 2'd2, 32'hFFFF_0000);
    evt(8'hA5);
    check("R7 irq after event", 32'(irq), 32'd1);
    bus(1'b0, 8'h04, 2'd2, 32'h0);
    check("R7 event value", rdata, 32'h0000_00A5);

    // R8 event and status read together
    evt(8'h80);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = 8'h04; size = 2'd2;
    evt_valid = 1'b1; evt_data = 8'h33;
    @(negedge clk);
    req = 1'b0; evt_valid = 1'b0;
    check("R8 read returns old", rdata, 32'h0000_0080);
    check("R8 irq kept", 32'(irq), 32'd1);
    bus(1'b0, 8'h04, 2'd2, 32'h0);
    check("R8 event survived read", rdata, 32'h0000_0033);

    // R8 event and status write together
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 8'h04; size = 2'd2; wdata = 32'h0000_1234;
    evt_valid = 1'b1; evt_data = 8'h01;
    @(negedge clk);
    req = 1'b0; we = 1'b0; evt_valid = 1'b0;
    bus(1'b0, 8'h04, 2'd2, 32'h0);
    check("R8 event beats write", rdata, 32'h0000_0001);

    // doorbells, empty table first
    bell("R10 empty table", 2'd2, 8'h0C, 32'h0000_0000, 1'b0, 16'h0, 8'h0);
    tbl(4'd2, 8'd3);
    tbl(4'd0, 8'd1);
    bell("R11 peer2 vec2", 2'd2, 8'h0C, 32'h0002_0002, 1'b1, 16'h2, 8'h2);
    bell("R10 vec at count", 2'd2, 8'h0C, 32'h0002_0003, 1'b0, 16'h0, 8'h0);
    bell("R10 dest above max", 2'd2, 8'h0C, 32'h0003_0000, 1'b0, 16'h0, 8'h0);
    bell("R10 dest far", 2'd2, 8'h0C, 32'h0100_0000, 1'b0, 16'h0, 8'h0);
    bell("R9 mid bits ignored", 2'd2, 8'h0C, 32'h0002_FF01, 1'b1, 16'h2, 8'h1);
    bell("R11 peer0 vec0", 2'd2, 8'h0C, 32'h0000_0000, 1'b1, 16'h0, 8'h0);
    bell("R5 byte doorbell", 2'd0, 8'h0C, 32'h0002_0000, 1'b0, 16'h0, 8'h0);
    bell("R3 doorbell at 0x0F", 2'd2, 8'h0F, 32'h0002_0001, 1'b1, 16'h2, 8'h1);
    tbl(4'd2, 8'd0);
    bell("R12 removed peer", 2'd2, 8'h0C, 32'h0002_0000, 1'b0, 16'h0, 8'h0);
    tbl(4'd5, 8'd1);
    bell("R10 zero count below max", 2'd2, 8'h0C, 32'h0003_0000, 1'b0, 16'h0, 8'h0);
    bell("R12 new peer5", 2'd2, 8'h0C, 32'h0005_0000, 1'b1, 16'h5, 8'h0);

    // back-to-back doorbells keep the strobe high for each
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 8'h0C; size = 2'd2; wdata = 32'h0000_0000;
    @(negedge clk);
    wdata = 32'h0005_0000;
    check("R11 first of pair", 32'(notify_peer), 32'h0);
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    check("R11 second of pair", 32'(notify_peer), 32'h5);
    @(negedge clk);
    check("R11 pair ends", 32'(notify), 32'd0);

    // R1 reset mid-run
    bus(1'b1, 8'h04, 2'd2, 32'h0000_0010);
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    check("R1 irq after reset", 32'(irq), 32'd0);
    bus(1'b0, 8'h04, 2'd2, 32'h0);
    check("R1 status after reset", rdata, 32'h0);
    bus(1'b0, 8'h00, 2'd2, 32'h0);
    check("R1 mask after reset", rdata, 32'h0);
    bell("R1 table after reset", 2'd2, 8'h0C, 32'h0005_0000, 1'b0, 16'h0, 8'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule